// File: doc/BRIEF.md
# Sub-Processor Gate and Mailbox Register Block

This block sits on the main processor's register bus and controls a secondary processor. From a 48-byte register window it drives the secondary processor's reset line, its bus-request line and a level-2 interrupt pulse. It also holds the state that other blocks use to share memory:

- a bank select and a write-protect boundary for the program memory;
- the two handoff bits for the shared work memory, named "give" (DMNA) and "returned" (RET);
- a gate signal that approves or refuses each main-side write into program memory.

A set of mailbox registers carries messages between the two processors. The 16-bit flag word is split: the main side owns its upper byte and the secondary side owns its lower byte. There are eight command words that the main side writes and the secondary side reads. There are eight status words that the secondary side writes and the main side reads.

The secondary side reaches the block through a plain write port. The same port carries a strobe that hands the work memory back. Main-side reads are combinational from the address. Main-side writes take effect on the clock edge at which `m_we` is high.

Top module: `sub_gate_ctrl`

## Requirements
- R1: After reset, `sub_hold` is 1 and `sub_busreq` is 0. The bank, write-protect, DMNA and RET are all 0. The flag, command, status and vector registers all read 0.
- R2: A write to offset 0x00 with `m_be[0]` set loads `sub_busreq` from data bit 1 and `sub_hold` from the inverse of data bit 0. A write with `m_be[0]` clear leaves both unchanged.
- R3: A write to offset 0x00 with `m_be[1]` set, data bit 8 at 1 and `irq2_en` at 1 makes `sub_irq2` high for exactly the following cycle. With `irq2_en` at 0, no pulse is produced.
- R4: A read of offset 0x00 returns `irq2_en` in bit 15, `sub_busreq` in bit 1 and `~sub_hold` in bit 0. All other bits read 0.
- R5: A write to offset 0x02 sets the bank and the handoff state as follows:
  - With `m_be[1]` set, data bits 15:8 load write-protect.
  - With `m_be[0]` set, data bits 7:6 load the bank.
  - With `m_be[0]` set and data bit 1 at 1, DMNA is set. In the same write, RET is cleared, but only if `wram_1m` is 0.
  - A 0 in data bit 1 leaves DMNA as it was.
- R6: A read of offset 0x02 returns write-protect in bits 15:8, the bank in bits 7:6, `wram_1m` in bit 2, DMNA in bit 1 and RET in bit 0. All other bits read 0.
- R7: A cycle with `wram_release` high clears DMNA and sets RET. If a main-side set of DMNA arrives in the same cycle, the main-side set wins.
- R8: `prg_wr_ok` equals the conjunction of three terms: `prg_req`, `sub_busreq`, and `prg_idx` at or above write-protect × 512. It is combinational.
- R9: Offset 0x06 is a 16-bit vector register. Writes are byte-masked by `m_be`, and reads return the stored value.
- R10: Main-side writes to the flag word at offset 0x0E change only its upper byte, under `m_be[1]`. A main-side write with `m_be[0]` set leaves the lower byte unchanged and makes `flag_lo_err` high for the following cycle. `sub_flag_we` loads the lower byte from `sub_flag_lo`. `mb_flag` always shows the whole word.
- R11: Command word i sits at offset 0x10+2i, for i from 0 to 7. Main-side writes to it are byte-masked. The main side reads it back at that offset, and `sub_cmd_q` shows command word `sub_idx`.
- R12: Status word i sits at offset 0x20+2i. It is loaded from `sub_wdata` when `sub_stat_we` is high and `sub_idx` = i. Main-side writes to it have no effect, and main-side reads return it.
- R13: Reads of offsets 0x04, 0x08, 0x0A, 0x0C and any offset from 0x30 up return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_we | input | 1 | Main-side write strobe |
| m_addr | input | 6 | Main-side byte offset in the window (even) |
| m_be | input | 2 | Byte enables: bit 1 is the upper byte, bit 0 is the lower byte |
| m_wdata | input | 16 | Main-side write data |
| m_rdata | output | 16 | Main-side read data for `m_addr` |
| irq2_en | input | 1 | Secondary-side enable for the level-2 interrupt |
| wram_1m | input | 1 | Work memory split mode (1 = split) |
| wram_release | input | 1 | Secondary side hands the work memory back |
| sub_flag_we | input | 1 | Secondary-side write of the flag lower byte |
| sub_flag_lo | input | 8 | Flag lower byte data |
| sub_stat_we | input | 1 | Secondary-side status word write |
| sub_idx | input | 3 | Secondary-side mailbox word index |
| sub_wdata | input | 16 | Secondary-side status data |
| sub_cmd_q | output | 16 | Command word selected by `sub_idx` |
| mb_flag | output | 16 | Full flag word |
| sub_hold | output | 1 | Secondary processor held in reset |
| sub_busreq | output | 1 | Secondary processor bus requested |
| sub_irq2 | output | 1 | One-cycle level-2 interrupt pulse |
| prg_bank | output | 2 | Program memory bank |
| prg_wprot | output | 8 | Write-protect boundary in 512-word units |
| wram_dmna | output | 1 | Work memory given to the secondary side |
| wram_ret | output | 1 | Work memory returned to the main side |
| prg_req | input | 1 | Main side attempts a program memory write |
| prg_idx | input | 16 | Word index within the bank for that write |
| prg_wr_ok | output | 1 | Program memory write permitted |
| flag_lo_err | output | 1 | One-cycle pulse: main side tried to write the flag lower byte |

## Verification
The bench sweeps the program-memory gate over several write-protect values at the index just below, at and just above each boundary. It does this with the bus both requested and released. A design that compares with the wrong sense, or that misses the ×512 scaling, would approve writes into the protected area.

The bench runs the handoff bits through both work-memory modes. A design that clears RET in split mode, or that lets a 0 in data bit 1 clear DMNA, would be caught.

It also covers byte-masked writes to every command word. It covers main-side write attempts on the status words and on the flag lower byte, which must leave the stored value unchanged. Finally, it drives control writes with either byte lane off. A design that ignored the byte enables would move the reset and bus-request lines, or raise interrupts, when it should not.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
   localparam int DW = 16;
   localparam int AW = 6;
   typedef logic [DW-1:0] word_t;

   localparam logic [AW-1:0] OFS_CTRL = 6'h00;
   localparam logic [AW-1:0] OFS_MEM  = 6'h02;
   localparam logic [AW-1:0] OFS_HVEC = 6'h06;
   localparam logic [AW-1:0] OFS_FLAG = 6'h0E;
   localparam logic [1:0]    SEG_CMD  = 2'b01;
   localparam logic [1:0]    SEG_STAT = 2'b10;

   // Byte-lane merge of new data into an old word
   function automatic word_t lane_merge(word_t old_w, word_t new_w, logic [DW/8-1:0] be);
      word_t r;
      for (int i = 0; i < DW/8; i++)
         r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
      return r;
   endfunction
endpackage

// File: rtl/sgc_lanereg.sv
module sgc_lanereg #(
   parameter int LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LANES-1:0]   be,
   input  logic [LANES*8-1:0] d,
   output logic [LANES*8-1:0] q
);
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              q[g*8 +: 8] <= '0;
            else if (we && be[g])    q[g*8 +: 8] <= d[g*8 +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/sgc_gate.sv
module sgc_gate
   import sgc_pkg::*;
#(
   parameter int WP_W    = 8,
   parameter int BANK_W  = 2,
   parameter int IDX_W   = 16,
   parameter int UNIT_LG = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              mem_wr,
   input  logic [1:0]        be,
   input  word_t             wdata,
   input  logic              irq2_en,
   input  logic              wram_1m,
   input  logic              wram_release,
   input  logic              prg_req,
   input  logic [IDX_W-1:0]  prg_idx,
   output logic              sub_hold,
   output logic              sub_busreq,
   output logic              sub_irq2,
   output logic [BANK_W-1:0] prg_bank,
   output logic [WP_W-1:0]   prg_wprot,
   output logic              wram_dmna,
   output logic              wram_ret,
   output logic              prg_wr_ok
);
   localparam int CMP_W = (WP_W + UNIT_LG > IDX_W) ? WP_W + UNIT_LG : IDX_W;

   logic [CMP_W-1:0] bound, idx_x;
   logic             unused_wd;

   assign unused_wd = ^{wdata[5:2], wdata[15:9]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_hold   <= 1'b1;
         sub_busreq <= 1'b0;
         sub_irq2   <= 1'b0;
      end else begin
         sub_irq2 <= ctrl_wr && be[1] && wdata[8] && irq2_en;
         if (ctrl_wr && be[0]) begin
            sub_busreq <= wdata[1];
            sub_hold   <= ~wdata[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prg_wprot <= '0;
         prg_bank  <= '0;
         wram_dmna <= 1'b0;
         wram_ret  <= 1'b0;
      end else begin
         if (wram_release) begin
            wram_dmna <= 1'b0;
            wram_ret  <= 1'b1;
         end
         if (mem_wr && be[1]) prg_wprot <= wdata[15:8];
         if (mem_wr && be[0]) begin
            prg_bank <= wdata[7:6];
            if (wdata[1]) begin
               wram_dmna <= 1'b1;
               if (!wram_1m) wram_ret <= 1'b0;
            end
         end
      end
   end

   assign bound     = CMP_W'({prg_wprot, {UNIT_LG{1'b0}}});
   assign idx_x     = CMP_W'(prg_idx);
   assign prg_wr_ok = prg_req && sub_busreq && (idx_x >= bound);
endmodule

// File: rtl/sgc_mailbox.sv
module sgc_mailbox
   import sgc_pkg::*;
#(
   parameter int N_MB = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flag_wr,
   input  logic       cmd_wr,
   input  logic [2:0] m_idx,
   input  logic [1:0] be,
   input  word_t      wdata,
   input  logic       sub_flag_we,
   input  logic [7:0] sub_flag_lo,
   input  logic       sub_stat_we,
   input  logic [2:0] sub_idx,
   input  word_t      sub_wdata,
   output word_t      flag_q,
   output word_t      cmd_rd,
   output word_t      stat_rd,
   output word_t      sub_cmd_q,
   output logic       flag_lo_err
);
   word_t cmd_r  [N_MB];
   word_t stat_r [N_MB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q      <= '0;
         flag_lo_err <= 1'b0;
      end else begin
         flag_lo_err <= flag_wr && be[0];
         if (flag_wr && be[1]) flag_q[15:8] <= wdata[15:8];
         if (sub_flag_we)      flag_q[7:0]  <= sub_flag_lo;
      end
   end

   generate
      for (genvar g = 0; g < N_MB; g++) begin : g_word
         sgc_lanereg #(.LANES(2)) i_cmd (
            .clk(clk), .rst_n(rst_n),
            .we(cmd_wr && (m_idx == 3'(g))), .be(be),
            .d(wdata), .q(cmd_r[g])
         );
         sgc_lanereg #(.LANES(2)) i_stat (
            .clk(clk), .rst_n(rst_n),
            .we(sub_stat_we && (sub_idx == 3'(g))), .be(2'b11),
            .d(sub_wdata), .q(stat_r[g])
         );
      end
   endgenerate

   always_comb begin
      cmd_rd    = '0;
      stat_rd   = '0;
      sub_cmd_q = '0;
      for (int i = 0; i < N_MB; i++) begin
         if (m_idx == 3'(i)) begin
            cmd_rd  = cmd_r[i];
            stat_rd = stat_r[i];
         end
         if (sub_idx == 3'(i)) sub_cmd_q = cmd_r[i];
      end
   end
endmodule

// File: rtl/sub_gate_ctrl.sv
module sub_gate_ctrl
   import sgc_pkg::*;
#(
   parameter int N_MB    = 8,
   parameter int WP_W    = 8,
   parameter int BANK_W  = 2,
   parameter int IDX_W   = 16,
   parameter int UNIT_LG = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_we,
   input  logic [5:0]        m_addr,
   input  logic [1:0]        m_be,
   input  logic [15:0]       m_wdata,
   output logic [15:0]       m_rdata,
   input  logic              irq2_en,
   input  logic              wram_1m,
   input  logic              wram_release,
   input  logic              sub_flag_we,
   input  logic [7:0]        sub_flag_lo,
   input  logic              sub_stat_we,
   input  logic [2:0]        sub_idx,
   input  logic [15:0]       sub_wdata,
   output logic [15:0]       sub_cmd_q,
   output logic [15:0]       mb_flag,
   output logic              sub_hold,
   output logic              sub_busreq,
   output logic              sub_irq2,
   output logic [BANK_W-1:0] prg_bank,
   output logic [WP_W-1:0]   prg_wprot,
   output logic              wram_dmna,
   output logic              wram_ret,
   input  logic              prg_req,
   input  logic [IDX_W-1:0]  prg_idx,
   output logic              prg_wr_ok,
   output logic              flag_lo_err
);
   generate
      if (N_MB < 1 || N_MB > 8)  $error("N_MB must be 1..8");
      if (WP_W != 8)             $error("WP_W must be 8 to fit the upper byte");
      if (BANK_W != 2)           $error("BANK_W must be 2 to fit bits 7:6");
      if (IDX_W < 1)             $error("IDX_W must be positive");
   endgenerate

   logic       ctrl_wr, mem_wr, hvec_wr, flag_wr, cmd_wr;
   logic       cmd_hit, stat_hit;
   logic [2:0] m_idx;
   word_t      hvec_q, cmd_rd, stat_rd;

   assign m_idx    = m_addr[3:1];
   assign cmd_hit  = (m_addr[5:4] == SEG_CMD)  && !m_addr[0];
   assign stat_hit = (m_addr[5:4] == SEG_STAT) && !m_addr[0];
   assign ctrl_wr  = m_we && (m_addr == OFS_CTRL);
   assign mem_wr   = m_we && (m_addr == OFS_MEM);
   assign hvec_wr  = m_we && (m_addr == OFS_HVEC);
   assign flag_wr  = m_we && (m_addr == OFS_FLAG);
   assign cmd_wr   = m_we && cmd_hit;

   sgc_gate #(.WP_W(WP_W), .BANK_W(BANK_W), .IDX_W(IDX_W), .UNIT_LG(UNIT_LG)) i_gate (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .mem_wr(mem_wr),
      .be(m_be), .wdata(m_wdata), .irq2_en(irq2_en), .wram_1m(wram_1m),
      .wram_release(wram_release), .prg_req(prg_req), .prg_idx(prg_idx),
      .sub_hold(sub_hold), .sub_busreq(sub_busreq), .sub_irq2(sub_irq2),
      .prg_bank(prg_bank), .prg_wprot(prg_wprot), .wram_dmna(wram_dmna),
      .wram_ret(wram_ret), .prg_wr_ok(prg_wr_ok)
   );

   sgc_lanereg #(.LANES(2)) i_hvec (
      .clk(clk), .rst_n(rst_n), .we(hvec_wr), .be(m_be), .d(m_wdata), .q(hvec_q)
   );

   sgc_mailbox #(.N_MB(N_MB)) i_mb (
      .clk(clk), .rst_n(rst_n), .flag_wr(flag_wr), .cmd_wr(cmd_wr),
      .m_idx(m_idx), .be(m_be), .wdata(m_wdata),
      .sub_flag_we(sub_flag_we), .sub_flag_lo(sub_flag_lo),
      .sub_stat_we(sub_stat_we), .sub_idx(sub_idx), .sub_wdata(sub_wdata),
      .flag_q(mb_flag), .cmd_rd(cmd_rd), .stat_rd(stat_rd),
      .sub_cmd_q(sub_cmd_q), .flag_lo_err(flag_lo_err)
   );

   always_comb begin
      m_rdata = '0;
      if (m_addr == OFS_CTRL)      m_rdata = {irq2_en, 13'b0, sub_busreq, ~sub_hold};
      else if (m_addr == OFS_MEM)  m_rdata = {prg_wprot, prg_bank, 3'b0, wram_1m, wram_dmna, wram_ret};
      else if (m_addr == OFS_HVEC) m_rdata = hvec_q;
      else if (m_addr == OFS_FLAG) m_rdata = mb_flag;
      else if (cmd_hit)            m_rdata = cmd_rd;
      else if (stat_hit)           m_rdata = stat_rd;
   end
endmodule

// File: rtl/sub_gate_ctrl_chk.sv
module sub_gate_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        m_we,
   input logic [5:0]  m_addr,
   input logic [1:0]  m_be,
   input logic [15:0] m_wdata,
   input logic        irq2_en,
   input logic        wram_release,
   input logic        sub_flag_we,
   input logic [15:0] mb_flag,
   input logic        sub_hold,
   input logic        sub_busreq,
   input logic        sub_irq2,
   input logic        wram_dmna,
   input logic        prg_req,
   input logic        prg_wr_ok,
   input logic        flag_lo_err
);
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      sub_irq2 |-> $past(irq2_en && m_we && m_addr == 6'h00 && m_be[1] && m_wdata[8])); // R3

   AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sub_hold) |-> $past(m_we && m_addr == 6'h00 && m_be[0] && m_wdata[0])); // R2

   AST_PRG_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      prg_wr_ok |-> (sub_busreq && prg_req)); // R8

   AST_DMNA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wram_dmna) |-> $past(m_we && m_addr == 6'h02 && m_be[0] && m_wdata[1])); // R5

   AST_DMNA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wram_dmna) |-> $past(wram_release)); // R7

   AST_FLAG_LO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mb_flag[7:0]) |-> $past(sub_flag_we)); // R10

   AST_FLAG_LO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      flag_lo_err |-> $past(m_we && m_addr == 6'h0E && m_be[0])); // R10
endmodule

bind sub_gate_ctrl sub_gate_ctrl_chk i_chk (.*);

// File: tb/test_sub_gate_ctrl.sv
module test_sub_gate_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_we = 1'b0;
   logic [5:0]  m_addr = '0;
   logic [1:0]  m_be = '0;
   logic [15:0] m_wdata = '0;
   logic [15:0] m_rdata;
   logic        irq2_en = 1'b0;
   logic        wram_1m = 1'b0;
   logic        wram_release = 1'b0;
   logic        sub_flag_we = 1'b0;
   logic [7:0]  sub_flag_lo = '0;
   logic        sub_stat_we = 1'b0;
   logic [2:0]  sub_idx = '0;
   logic [15:0] sub_wdata = '0;
   logic [15:0] sub_cmd_q, mb_flag;
   logic        sub_hold, sub_busreq, sub_irq2;
   logic [1:0]  prg_bank;
   logic [7:0]  prg_wprot;
   logic        wram_dmna, wram_ret;
   logic        prg_req = 1'b0;
   logic [15:0] prg_idx = '0;
   logic        prg_wr_ok, flag_lo_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit irq_seen, err_seen;

   always #5 clk = ~clk;

   sub_gate_ctrl i_sub_gate_ctrl (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called in the low phase; the write lands on the next rising edge
   task automatic wr(logic [5:0] a, logic [1:0] be, logic [15:0] d);
      m_we = 1'b1; m_addr = a; m_be = be; m_wdata = d;
      @(negedge clk);
      irq_seen = sub_irq2;
      err_seen = flag_lo_err;
      m_we = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [5:0] a, logic [15:0] exp);
      m_addr = a;
      #1;
      chk(req, m_rdata, exp);
   endtask

   task automatic pulse_release();
      wram_release = 1'b1;
      @(negedge clk);
      wram_release = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: state after reset
      chk("R1 hold", sub_hold, 1);
      chk("R1 busreq", sub_busreq, 0);
      rd_chk("R1 ctrl", 6'h00, 16'h0000);
      rd_chk("R1 mem", 6'h02, 16'h0000);
      rd_chk("R1 hvec", 6'h06, 16'h0000);
      rd_chk("R1 flag", 6'h0E, 16'h0000);
      for (int i = 0; i < 8; i++) begin
         rd_chk("R1 cmd", 6'(6'h10 + 2*i), 16'h0000);
         rd_chk("R1 stat", 6'(6'h20 + 2*i), 16'h0000);
      end

      // R2 / R4: control byte lane behaviour
      wr(6'h00, 2'b01, 16'h0003);
      chk("R2 hold released", sub_hold, 0);
      chk("R2 busreq set", sub_busreq, 1);
      rd_chk("R4 ctrl read", 6'h00, 16'h0003);
      irq2_en = 1'b1;
      rd_chk("R4 ctrl read irq_en", 6'h00, 16'h8003);
      wr(6'h00, 2'b10, 16'h0000);
      chk("R2 upper-only keeps busreq", sub_busreq, 1);
      chk("R2 upper-only keeps hold", sub_hold, 0);
      wr(6'h00, 2'b01, 16'h0000);
      chk("R2 hold asserted", sub_hold, 1);
      chk("R2 busreq cleared", sub_busreq, 0);
      rd_chk("R4 ctrl read held", 6'h00, 16'h8000);

      // R3: interrupt pulse
      wr(6'h00, 2'b10, 16'h0100);
      chk("R3 pulse when enabled", irq_seen, 1);
      @(negedge clk);
      chk("R3 pulse one cycle", sub_irq2, 0);
      wr(6'h00, 2'b01, 16'h0100);
      chk("R3 no pulse without upper lane", irq_seen, 0);
      irq2_en = 1'b0;
      wr(6'h00, 2'b10, 16'h0100);
      chk("R3 no pulse when disabled", irq_seen, 0);

      // R5 / R6 / R7: memory mode and handoff
      pulse_release();
      rd_chk("R7 release sets ret", 6'h02, 16'h0001);
      wr(6'h02, 2'b11, 16'h5AC2);
      rd_chk("R5 R6 2M give", 6'h02, 16'h5AC2);
      chk("R5 bank port", prg_bank, 2'd3);
      chk("R5 wprot port", prg_wprot, 8'h5A);
      wr(6'h02, 2'b01, 16'h00C0);
      chk("R5 bit1 zero keeps dmna", wram_dmna, 1);
      pulse_release();
      rd_chk("R7 release", 6'h02, 16'h5AC1);
      wram_1m = 1'b1;
      wr(6'h02, 2'b01, 16'h0002);
      rd_chk("R5 R6 1M give keeps ret", 6'h02, 16'h5A07);
      wr(6'h02, 2'b10, 16'h0300);
      rd_chk("R5 upper-only write", 6'h02, 16'h0307);
      wram_1m = 1'b0;
      // R7: main set wins over release in the same cycle
      wram_release = 1'b1;
      wr(6'h02, 2'b01, 16'h0002);
      wram_release = 1'b0;
      chk("R7 main set wins dmna", wram_dmna, 1);
      chk("R7 main set wins ret", wram_ret, 0);

      // R8: program memory gate sweep
      begin
         logic [7:0] wps [5] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'hFF};
         for (int b = 0; b < 2; b++) begin
            wr(6'h00, 2'b01, b ? 16'h0003 : 16'h0001);
            for (int w = 0; w < 5; w++) begin
               wr(6'h02, 2'b10, {wps[w], 8'h00});
               for (int k = 0; k < 6; k++) begin
                  int bound;
                  int idx;
                  bound = int'(wps[w]) * 512;
                  case (k)
                     0: idx = 0;
                     1: idx = bound - 1;
                     2: idx = bound;
                     3: idx = bound + 1;
                     4: idx = 65535;
                     default: idx = bound + 511;
                  endcase
                  if (idx < 0) idx = 0;
                  if (idx > 65535) idx = 65535;
                  for (int r = 0; r < 2; r++) begin
                     prg_req = 1'(r);
                     prg_idx = 16'(idx);
                     #1;
                     chk("R8 prg gate", prg_wr_ok, (r == 1) && (b == 1) && (idx >= bound));
                  end
               end
            end
         end
         prg_req = 1'b0;
      end

      // R9: vector register
      wr(6'h06, 2'b11, 16'h1234);
      rd_chk("R9 full", 6'h06, 16'h1234);
      wr(6'h06, 2'b01, 16'hABCD);
      rd_chk("R9 low lane", 6'h06, 16'h12CD);
      wr(6'h06, 2'b10, 16'hEF00);
      rd_chk("R9 high lane", 6'h06, 16'hEFCD);

      // R10: flag split ownership
      wr(6'h0E, 2'b11, 16'hA55A);
      chk("R10 low write flagged", err_seen, 1);
      rd_chk("R10 main upper only", 6'h0E, 16'hA500);
      sub_flag_we = 1'b1; sub_flag_lo = 8'h3C;
      @(negedge clk);
      sub_flag_we = 1'b0;
      chk("R10 sub low byte", mb_flag, 16'hA53C);
      wr(6'h0E, 2'b10, 16'h7700);
      chk("R10 upper write not flagged", err_seen, 0);
      rd_chk("R10 merged", 6'h0E, 16'h773C);

      // R11: command words
      for (int i = 0; i < 8; i++) begin
         logic [15:0] v;
         v = 16'(16'h1111 * (i + 1)) ^ 16'h0F0F;
         wr(6'(6'h10 + 2*i), 2'b11, v);
         wr(6'(6'h10 + 2*i), 2'(1 + (i % 2)), 16'hFFFF);
         v = (i % 2) ? {8'hFF, v[7:0]} : {v[15:8], 8'hFF};
         rd_chk("R11 main readback", 6'(6'h10 + 2*i), v);
         sub_idx = 3'(i);
         #1;
         chk("R11 sub view", sub_cmd_q, v);
      end

      // R12: status words
      for (int i = 0; i < 8; i++) begin
         sub_stat_we = 1'b1; sub_idx = 3'(i); sub_wdata = 16'(16'hC000 + i * 16'h0101);
         @(negedge clk);
         sub_stat_we = 1'b0;
         wr(6'(6'h20 + 2*i), 2'b11, 16'hFFFF);
         rd_chk("R12 status main write ignored", 6'(6'h20 + 2*i), 16'(16'hC000 + i * 16'h0101));
      end

      // R13: unmapped offsets
      rd_chk("R13 04", 6'h04, 16'h0000);
      rd_chk("R13 08", 6'h08, 16'h0000);
      rd_chk("R13 0A", 6'h0A, 16'h0000);
      rd_chk("R13 0C", 6'h0C, 16'h0000);
      rd_chk("R13 30", 6'h30, 16'h0000);
      rd_chk("R13 3E", 6'h3E, 16'h0000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule